// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block is a circular queue. It holds instructions that are in flight, together with their results, from dispatch until retirement. Dispatch reserves one slot per cycle at the tail, in program order, and receives the slot index as the instruction's tag. Execution units return results in any order, addressed by that tag. Results stay inside the queue until the oldest entry has completed. At that point the entry is presented on the retirement port, and a register-file write port consumes it. Later instructions can read a completed but unretired result by tag on a bypass port.

A writeback can carry a mispredicted-branch flag. In that case every entry younger than the branch is discarded in the same cycle, and allocation resumes right after the branch. A writeback can also carry an exception flag. That flag only acts once the entry reaches the head: retirement is held, the exception port reports the entry's tag, and the whole queue is emptied. Architectural state is therefore updated only by retirement, and the update stops exactly at the faulting instruction.

Top module: `rob_core`

## Requirements
- R1: After reset the queue is empty. `alloc_ready_o` is 1, `alloc_tag_o` is 0, and `commit_valid_o` and `exc_valid_o` are 0.
- R2: Each accepted allocation receives the tag shown on `alloc_tag_o` in that cycle. Successive tags increase by one modulo DEPTH.
- R3: With DEPTH entries outstanding, `alloc_ready_o` is 0. An allocation request in that state is ignored and `alloc_tag_o` does not advance.
- R4: Retirement presents at most one entry per cycle, always the oldest. It presents the entry only once its result has been written. `commit_tag_o`, `commit_dest_o` and `commit_data_o` give the tag, the destination index from allocation, and the written result. The retirement port reflects registered state: a result written at edge k can retire in the cycle after edge k.
- R5: A completed younger entry never retires before an older incomplete one.
- R6: For a tag that is allocated and completed, `rd_ready_o` is 1 and `rd_data_o` is its result. For an allocated entry that has not completed, `rd_ready_o` is 0.
- R7: A writeback to a tag that is not allocated, or that has already completed, changes nothing.
- R8: A writeback with `wb_mispred_i`=1 to a live entry completes that entry, discards all younger entries in that edge, and sets the next allocation tag to the branch tag plus one. The branch itself retires normally. Discarded entries never retire and read as not ready.
- R9: When the oldest entry has completed with `wb_exc_i`=1, that entry does not retire. Instead `exc_valid_o` is 1 with `exc_tag_o` equal to its tag. At the next edge the queue is empty and the next allocation tag is 0.
- R10: `alloc_ready_o` is 0 in any cycle that carries a mispredict flush or an exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Allocation request |
| alloc_dest_i | input | $clog2(NREG) | Destination register index of the new entry |
| alloc_ready_o | output | 1 | Allocation accepted this cycle if requested |
| alloc_tag_o | output | $clog2(DEPTH) | Tag given to the entry being allocated |
| wb_valid_i | input | 1 | Result writeback strobe |
| wb_tag_i | input | $clog2(DEPTH) | Tag of the written entry |
| wb_data_i | input | XLEN | Result value |
| wb_exc_i | input | 1 | Entry raised an exception |
| wb_mispred_i | input | 1 | Entry is a mispredicted branch |
| rd_tag_i | input | $clog2(DEPTH) | Bypass read tag |
| rd_ready_o | output | 1 | Bypass entry is live and completed |
| rd_data_o | output | XLEN | Bypass result |
| commit_valid_o | output | 1 | Head entry retires this cycle |
| commit_tag_o | output | $clog2(DEPTH) | Tag of retiring entry |
| commit_dest_o | output | $clog2(NREG) | Register index to write |
| commit_data_o | output | XLEN | Value to write |
| exc_valid_o | output | 1 | Head entry faults; queue is flushed |
| exc_tag_o | output | $clog2(DEPTH) | Tag of faulting entry |

## Verification
The hardest case to reach is a misprediction that resolves while the queue has already wrapped. Some of the squashed entries have also completed, and the branch is not at the head. The stimulus first cycles the head pointer around the ring with full-queue and stray-writeback phases. It then allocates across the wrap point and completes one younger entry before resolving the branch. A fresh allocation is made into the freed tag, which proves that the old result never retires. An exception with a completed younger entry behind it follows, so that the full flush and the restart at tag 0 are both observed.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef struct packed {
    logic valid;
    logic done;
    logic exc;
  } rob_flag_t;
endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          alloc_valid_i,
  input  rob_flag_t     head_flag_i,
  input  logic          wb_valid_i,
  input  logic [IW-1:0] wb_tag_i,
  input  logic          wb_mispred_i,
  input  logic          wb_live_i,
  output logic [IW-1:0] head_o,
  output logic [IW-1:0] tail_o,
  output logic [IW:0]   count_o,
  output logic          alloc_ready_o,
  output logic          alloc_fire_o,
  output logic          commit_fire_o,
  output logic          exc_fire_o,
  output logic          bflush_o
);
  localparam logic [IW:0] FULL_CNT = (IW+1)'(DEPTH);

  logic [IW-1:0] head_q, tail_q, br_off;
  logic [IW:0]   count_q, keep_cnt;
  logic          head_ok;

  assign head_ok       = head_flag_i.valid && head_flag_i.done;
  assign exc_fire_o    = head_ok && head_flag_i.exc;
  assign commit_fire_o = head_ok && !head_flag_i.exc;
  assign bflush_o      = wb_valid_i && wb_mispred_i && wb_live_i && !exc_fire_o;
  assign alloc_ready_o = (count_q != FULL_CNT) && !bflush_o && !exc_fire_o;
  assign alloc_fire_o  = alloc_valid_i && alloc_ready_o;

  // entries kept on a flush: head through the branch inclusive
  assign br_off   = wb_tag_i - head_q;
  assign keep_cnt = {1'b0, br_off} + (IW+1)'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else if (exc_fire_o) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (commit_fire_o) head_q <= head_q + IW'(1);
      if (bflush_o) begin
        tail_q  <= wb_tag_i + IW'(1);
        count_q <= keep_cnt - (IW+1)'(commit_fire_o);
      end else begin
        if (alloc_fire_o) tail_q <= tail_q + IW'(1);
        count_q <= count_q + (IW+1)'(alloc_fire_o) - (IW+1)'(commit_fire_o);
      end
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign count_o = count_q;

  // R8
  flush_tail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bflush_o |=> (tail_q == $past(wb_tag_i) + IW'(1)));
  // R9
  exc_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_fire_o |=> (count_q == '0 && head_q == '0 && tail_q == '0));
endmodule

// File: rtl/rob_store.sv
module rob_store
  import rob_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int XLEN  = 32,
  parameter int NREG  = 32,
  localparam int IW = $clog2(DEPTH),
  localparam int RW = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            alloc_fire_i,
  input  logic [IW-1:0]   tail_i,
  input  logic [RW-1:0]   alloc_dest_i,
  input  logic            commit_fire_i,
  input  logic [IW-1:0]   head_i,
  input  logic            wb_valid_i,
  input  logic [IW-1:0]   wb_tag_i,
  input  logic [XLEN-1:0] wb_data_i,
  input  logic            wb_exc_i,
  input  logic            bflush_i,
  input  logic            exc_fire_i,
  input  logic [IW-1:0]   rd_tag_i,
  output rob_flag_t       head_flag_o,
  output logic [RW-1:0]   head_dest_o,
  output logic [XLEN-1:0] head_data_o,
  output logic            wb_live_o,
  output logic            rd_ready_o,
  output logic [XLEN-1:0] rd_data_o,
  output logic [DEPTH-1:0] valid_o
);
  rob_flag_t       flag_w [DEPTH];
  logic [RW-1:0]   dest_w [DEPTH];
  logic [XLEN-1:0] data_w [DEPTH];
  logic [IW-1:0]   br_off;
  logic            wb_take;

  assign wb_live_o = flag_w[wb_tag_i].valid && !flag_w[wb_tag_i].done;
  assign wb_take   = wb_valid_i && wb_live_o;
  assign br_off    = wb_tag_i - head_i;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    localparam logic [IW-1:0] IDX = IW'(i);
    rob_flag_t       f_q;
    logic [RW-1:0]   d_q;
    logic [XLEN-1:0] r_q;
    logic [IW-1:0]   off;
    logic            squash;

    assign off    = IDX - head_i;
    assign squash = exc_fire_i || (bflush_i && (off > br_off));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        f_q <= '0;
      end else if (squash) begin
        f_q.valid <= 1'b0;
      end else begin
        if (alloc_fire_i && tail_i == IDX)
          f_q <= '{valid: 1'b1, done: 1'b0, exc: 1'b0};
        else if (commit_fire_i && head_i == IDX)
          f_q.valid <= 1'b0;
        if (wb_take && wb_tag_i == IDX) begin
          f_q.done <= 1'b1;
          f_q.exc  <= wb_exc_i;
        end
      end
    end

    always_ff @(posedge clk_i) begin
      if (alloc_fire_i && tail_i == IDX) d_q <= alloc_dest_i;
      if (wb_take && wb_tag_i == IDX)    r_q <= wb_data_i;
    end

    assign flag_w[i]  = f_q;
    assign dest_w[i]  = d_q;
    assign data_w[i]  = r_q;
    assign valid_o[i] = f_q.valid;
  end

  assign head_flag_o = flag_w[head_i];
  assign head_dest_o = dest_w[head_i];
  assign head_data_o = data_w[head_i];
  assign rd_ready_o  = flag_w[rd_tag_i].valid && flag_w[rd_tag_i].done;
  assign rd_data_o   = data_w[rd_tag_i];

  // R3
  no_overwrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_fire_i |-> !flag_w[tail_i].valid);
endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int XLEN  = 32,
  parameter int NREG  = 32,
  localparam int IW = $clog2(DEPTH),
  localparam int RW = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            alloc_valid_i,
  input  logic [RW-1:0]   alloc_dest_i,
  output logic            alloc_ready_o,
  output logic [IW-1:0]   alloc_tag_o,
  input  logic            wb_valid_i,
  input  logic [IW-1:0]   wb_tag_i,
  input  logic [XLEN-1:0] wb_data_i,
  input  logic            wb_exc_i,
  input  logic            wb_mispred_i,
  input  logic [IW-1:0]   rd_tag_i,
  output logic            rd_ready_o,
  output logic [XLEN-1:0] rd_data_o,
  output logic            commit_valid_o,
  output logic [IW-1:0]   commit_tag_o,
  output logic [RW-1:0]   commit_dest_o,
  output logic [XLEN-1:0] commit_data_o,
  output logic            exc_valid_o,
  output logic [IW-1:0]   exc_tag_o
);
  rob_flag_t        head_flag;
  logic [IW-1:0]    head, tail;
  logic [IW:0]      count;
  logic             alloc_fire, commit_fire, exc_fire, bflush, wb_live;
  logic [DEPTH-1:0] valid_vec;

  rob_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni,
    .alloc_valid_i,
    .head_flag_i   (head_flag),
    .wb_valid_i,
    .wb_tag_i,
    .wb_mispred_i,
    .wb_live_i     (wb_live),
    .head_o        (head),
    .tail_o        (tail),
    .count_o       (count),
    .alloc_ready_o,
    .alloc_fire_o  (alloc_fire),
    .commit_fire_o (commit_fire),
    .exc_fire_o    (exc_fire),
    .bflush_o      (bflush)
  );

  rob_store #(.DEPTH(DEPTH), .XLEN(XLEN), .NREG(NREG)) u_store (
    .clk_i, .rst_ni,
    .alloc_fire_i  (alloc_fire),
    .tail_i        (tail),
    .alloc_dest_i,
    .commit_fire_i (commit_fire),
    .head_i        (head),
    .wb_valid_i,
    .wb_tag_i,
    .wb_data_i,
    .wb_exc_i,
    .bflush_i      (bflush),
    .exc_fire_i    (exc_fire),
    .rd_tag_i,
    .head_flag_o   (head_flag),
    .head_dest_o   (commit_dest_o),
    .head_data_o   (commit_data_o),
    .wb_live_o     (wb_live),
    .rd_ready_o,
    .rd_data_o,
    .valid_o       (valid_vec)
  );

  assign alloc_tag_o    = tail;
  assign commit_valid_o = commit_fire;
  assign commit_tag_o   = head;
  assign exc_valid_o    = exc_fire;
  assign exc_tag_o      = head;

  // R2
  count_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(valid_vec) == int'(count));
  // R4
  in_order_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_valid_o |=> (!commit_valid_o || commit_tag_o == $past(commit_tag_o) + IW'(1)));
  // R9
  exc_no_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_o |=> !commit_valid_o);
endmodule

// File: tb/rob_core_bench.sv
module rob_core_bench;
  localparam int DEPTH = 8;
  localparam int XLEN  = 32;
  localparam int NREG  = 32;
  localparam int IW    = $clog2(DEPTH);
  localparam int RW    = $clog2(NREG);

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            alloc_valid_i = 1'b0;
  logic [RW-1:0]   alloc_dest_i = '0;
  logic            alloc_ready_o;
  logic [IW-1:0]   alloc_tag_o;
  logic            wb_valid_i = 1'b0;
  logic [IW-1:0]   wb_tag_i = '0;
  logic [XLEN-1:0] wb_data_i = '0;
  logic            wb_exc_i = 1'b0;
  logic            wb_mispred_i = 1'b0;
  logic [IW-1:0]   rd_tag_i = '0;
  logic            rd_ready_o;
  logic [XLEN-1:0] rd_data_o;
  logic            commit_valid_o;
  logic [IW-1:0]   commit_tag_o;
  logic [RW-1:0]   commit_dest_o;
  logic [XLEN-1:0] commit_data_o;
  logic            exc_valid_o;
  logic [IW-1:0]   exc_tag_o;

  always #4ns clk_i = ~clk_i;

  rob_core #(.DEPTH(DEPTH), .XLEN(XLEN), .NREG(NREG)) u_rob_core (.*);

  typedef struct { int tag; int dest; } exp_t;
  exp_t sbq[$];
  int   exp_data [DEPTH];
  bit   exp_done [DEPTH];
  bit   exp_exc  [DEPTH];
  int   checks = 0, failures = 0;
  bit   running = 1'b0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  function automatic int pos_of(int tag);
    foreach (sbq[k]) if (sbq[k].tag == tag) return k;
    return -1;
  endfunction

  task automatic alloc(int dest, output int tag);
    bit rdy;
    alloc_valid_i = 1'b1;
    alloc_dest_i  = RW'(dest);
    #0;
    rdy = alloc_ready_o;
    tag = int'(alloc_tag_o);
    step();
    alloc_valid_i = 1'b0;
    if (rdy) begin
      sbq.push_back('{tag: tag, dest: dest});
      exp_done[tag] = 1'b0;
      exp_exc[tag]  = 1'b0;
    end
  endtask

  task automatic wb(int tag, int data, bit exc, bit mis, bit blk);
    bit live;
    live = (pos_of(tag) >= 0) && !exp_done[tag];
    wb_valid_i   = 1'b1;
    wb_tag_i     = IW'(tag);
    wb_data_i    = XLEN'(data);
    wb_exc_i     = exc;
    wb_mispred_i = mis;
    if (blk) begin
      #1;
      // R10
      chk(alloc_ready_o == 1'b0, "R10", "alloc_ready during flush", alloc_ready_o, 0);
    end
    step();
    wb_valid_i = 1'b0; wb_exc_i = 1'b0; wb_mispred_i = 1'b0;
    if (live) begin
      exp_data[tag] = data;
      exp_done[tag] = 1'b1;
      exp_exc[tag]  = exc;
      if (mis) begin
        int k;
        k = pos_of(tag);
        while (sbq.size() > k + 1) void'(sbq.pop_back());
      end
    end
  endtask

  task automatic drain();
    for (int n = 0; n < 30 && sbq.size() != 0; n++) step();
    // R4
    chk(sbq.size() == 0, "R4", "all expected entries retired", sbq.size(), 0);
  endtask

  task automatic rd_chk(int tag, bit exp_rdy, int exp_val, string req);
    rd_tag_i = IW'(tag);
    #1;
    chk(rd_ready_o == exp_rdy, req, "rd_ready", rd_ready_o, exp_rdy);
    if (exp_rdy) chk(rd_data_o == XLEN'(exp_val), req, "rd_data", rd_data_o, exp_val);
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && running) begin
      if (exc_valid_o) begin
        if (sbq.size() == 0) chk(1'b0, "R9", "exception with empty model", exc_tag_o, -1);
        else begin
          chk(int'(exc_tag_o) == sbq[0].tag, "R9", "exc_tag", exc_tag_o, sbq[0].tag);
          chk(exp_exc[sbq[0].tag], "R9", "exception flag expected", 0, 1);
        end
        sbq.delete();
      end
      if (commit_valid_o) begin
        if (sbq.size() == 0) chk(1'b0, "R8", "spurious retirement tag", commit_tag_o, -1);
        else begin
          exp_t e;
          e = sbq.pop_front();
          chk(int'(commit_tag_o) == e.tag, "R4", "commit_tag", commit_tag_o, e.tag);
          chk(int'(commit_dest_o) == e.dest, "R4", "commit_dest", commit_dest_o, e.dest);
          // R5: only completed entries may retire
          chk(exp_done[e.tag] && !exp_exc[e.tag], "R5", "retired before completion", 0, 1);
          chk(commit_data_o == XLEN'(exp_data[e.tag]), "R4", "commit_data",
              commit_data_o, exp_data[e.tag]);
        end
      end
    end
  end

  initial begin
    #(8ns * 100000);
    failures++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int t;
    int tags[8];
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    #1;
    // R1
    chk(alloc_ready_o == 1'b1, "R1", "alloc_ready", alloc_ready_o, 1);
    chk(alloc_tag_o == '0, "R1", "alloc_tag", alloc_tag_o, 0);
    chk(commit_valid_o == 1'b0, "R1", "commit_valid", commit_valid_o, 0);
    chk(exc_valid_o == 1'b0, "R1", "exc_valid", exc_valid_o, 0);
    running = 1'b1;
    step();

    // R2, R5, R6: out-of-order completion
    for (int i = 0; i < 4; i++) begin
      alloc(i + 1, t);
      chk(t == i, "R2", "allocated tag", t, i);
    end
    wb(2, 32'h2002, 0, 0, 0);
    chk(commit_valid_o == 1'b0, "R5", "younger done, head pending", commit_valid_o, 0);
    rd_chk(2, 1'b1, 32'h2002, "R6");
    rd_chk(3, 1'b0, 0, "R6");
    wb(0, 32'h1000, 0, 0, 0);
    wb(3, 32'h3003, 0, 0, 0);
    wb(1, 32'h1001, 0, 0, 0);
    drain();

    // R3: full queue across the wrap
    for (int i = 0; i < DEPTH; i++) begin
      alloc(10 + i, t);
      tags[i] = t;
      chk(t == (4 + i) % DEPTH, "R2", "wrapped tag", t, (4 + i) % DEPTH);
    end
    alloc_valid_i = 1'b1;
    #1;
    chk(alloc_ready_o == 1'b0, "R3", "alloc_ready when full", alloc_ready_o, 0);
    step();
    alloc_valid_i = 1'b0;
    chk(int'(alloc_tag_o) == 4, "R3", "tag held when full", alloc_tag_o, 4);
    for (int i = DEPTH - 1; i >= 0; i--) wb(tags[i], 32'h5000 + i, 0, 0, 0);
    drain();

    // R7: stray and repeated writebacks
    wb(6, 32'hDEAD, 0, 0, 0);
    rd_chk(6, 1'b0, 0, "R7");
    for (int i = 0; i < 3; i++) alloc(20 + i, t);
    rd_chk(6, 1'b0, 0, "R7");
    wb(6, 32'h0066, 0, 0, 0);
    wb(6, 32'h0077, 0, 0, 0);
    rd_chk(6, 1'b1, 32'h0066, "R7");
    wb(4, 32'h0044, 0, 0, 0);
    wb(5, 32'h0055, 0, 0, 0);
    drain();

    // R8: mispredict with a completed younger entry, across the wrap
    for (int i = 0; i < 5; i++) alloc(3 + i, t);
    wb(1, 32'hBAD1, 0, 0, 0);
    wb(0, 32'h0B0B, 0, 1, 1);
    chk(int'(alloc_tag_o) == 1, "R8", "next tag after flush", alloc_tag_o, 1);
    rd_chk(1, 1'b0, 0, "R8");
    alloc(9, t);
    chk(t == 1, "R8", "reallocated tag", t, 1);
    wb(1, 32'h9999, 0, 0, 0);
    wb(7, 32'h7777, 0, 0, 0);
    drain();

    // R9: exception at head with completed younger entry
    for (int i = 0; i < 3; i++) alloc(12 + i, t);
    wb(3, 32'h3333, 0, 0, 0);
    wb(2, 32'h2222, 1, 0, 0);
    chk(exc_valid_o == 1'b1, "R9", "exc_valid", exc_valid_o, 1);
    chk(int'(exc_tag_o) == 2, "R9", "exc_tag", exc_tag_o, 2);
    chk(commit_valid_o == 1'b0, "R9", "no retirement on fault", commit_valid_o, 0);
    chk(alloc_ready_o == 1'b0, "R10", "alloc_ready on fault", alloc_ready_o, 0);
    step();
    chk(exc_valid_o == 1'b0, "R9", "exception cleared", exc_valid_o, 0);
    chk(alloc_tag_o == '0, "R9", "tag restarts at 0", alloc_tag_o, 0);
    chk(alloc_ready_o == 1'b1, "R9", "ready after flush", alloc_ready_o, 1);
    alloc(30, t);
    wb(t, 32'hC0DE, 0, 0, 0);
    drain();

    repeat (3) step();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule